// File: doc/BRIEF.md
# UART Register and Interrupt Unit

This block is the register front end of a serial port. It sits on a simple peripheral bus that carries a byte address, a write strobe, a read strobe, write data and read data. Reads are combinational from the address. A write or a read side effect takes effect at the next rising clock edge.

The block passes bytes to a serializer and takes bytes from it. It keeps an 11-bit raw interrupt vector and a mask register. From these it drives one level-sensitive interrupt line. The line rises a fixed number of cycles, `IRQ_DELAY`, after the masked set becomes non-empty. It drops in the same cycle that the masked set becomes empty, and that drop also cancels any pending assertion.

The divisor, line-format, control and FIFO-threshold registers only store values for software to read back. They have no effect on behaviour. A read-only identification block reports a fixed 64-bit value, one byte per word.

Top module: `uart_regif`

## Requirements
- R1: After reset, `irq` is 0, and the mask (0x038), raw status (0x03C) and control (0x030) registers all read 0.
- R2: The five storage registers hold all 16 written bits and read them back unchanged. They are: integer divisor 0x024, fractional divisor 0x028, line format 0x02C, control 0x030 and FIFO threshold 0x034.
- R3: A write to the data register (0x000) produces a one-cycle `tx_valid` pulse in the next cycle. The pulse carries `wdata[7:0]` on `tx_byte`. The write also sets raw bit 5 (transmit).
- R4: A cycle with `rx_valid` high stores `rx_byte`, sets raw bit 4 (receive) and clears flag bit 4 (receive empty). A read of 0x000 returns the stored byte in bits 7:0, clears raw bit 4 and sets flag bit 4 again.
- R5: A read of the masked status register (0x040) returns raw AND mask. The mask reads back as the low 11 bits of the value written to 0x038.
- R6: A write to the clear register (0x044) clears each raw bit that is 1 in `wdata[10:0]`. A set request for the same bit in the same cycle takes priority over the clear.
- R7: A 1 on `evt_set[i]` sets raw bit i. The bit order is: 0 ring, 1 CTS, 2 carrier, 3 DSR, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun.
- R8: When raw AND mask becomes non-zero after being zero, `irq` goes high exactly `IRQ_DELAY` clock edges later, provided the masked set stays non-empty for that whole time.
- R9: `irq` is low in every cycle where raw AND mask is zero. If the set empties before the delay runs out, the pending assertion is dropped, and a later non-empty set starts a full new delay.
- R10: A write to the mask register that makes raw AND mask non-zero schedules `irq` under the same rule as R8.
- R11: The flags register (0x018) reports `cts_in` in bit 0, receive empty in bit 4 and `tx_empty_in` in bit 7. All its other bits read 0.
- R12: The word at byte offset 0xFE0 + 4*i (i = 0..7) reads byte i of 0xB105F00D00341011 in bits 7:0, with byte 0 as the least significant byte.
- R13: Reads from unmapped offsets return 0. Writes to flags, raw status, masked status and identification offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Word-aligned byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for the data-read side effect) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| tx_valid | output | 1 | One-cycle pulse: byte for the transmitter |
| tx_byte | output | 8 | Byte for the transmitter |
| rx_valid | input | 1 | One-cycle pulse: received byte present |
| rx_byte | input | 8 | Received byte |
| cts_in | input | 1 | Clear-to-send level, reported in the flags register |
| tx_empty_in | input | 1 | Transmitter idle level, reported in the flags register |
| evt_set | input | 11 | Per-bit set requests for raw interrupt status |
| irq | output | 1 | Level interrupt output |

## Verification
The interrupt rule is exercised in three ways. In the first, the masked set turns non-empty through a mask write on an already-set raw bit. In the second, it turns non-empty through an event on an already-unmasked bit. Each of these confirms the exact edge on which `irq` rises. In the third, the set is emptied before the delay runs out, which separates a correct cancel from a counter that keeps running. The clear-versus-set collision and the byte path in both directions are checked at the register interface. The checks include the receive bit and the receive-empty flag moving in opposite directions.

// File: rtl/uart_regif_pkg.sv
// Package: shared widths, register byte offsets, raw-status bit indices and
// the identification constant for the UART register unit.
package uart_regif_pkg;
    localparam int ADDR_W  = 12;
    localparam int REG_W   = 16;
    localparam int INT_W   = 11;
    localparam int BYTE_W  = 8;
    localparam int N_STORE = 5;
    localparam int ID_BYTES = 8;

    localparam logic [ADDR_W-1:0] OFF_DATA  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_FLAGS = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_MSKD  = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_ID    = 12'hFE0;

    // Storage-only registers: int divisor, frac divisor, line format, control, threshold
    localparam logic [ADDR_W-1:0] STORE_OFF [N_STORE] =
        '{12'h024, 12'h028, 12'h02C, 12'h030, 12'h034};

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;

    localparam int FLG_CTS = 0;
    localparam int FLG_RXE = 4;
    localparam int FLG_TXE = 7;

    localparam logic [63:0] ID_VALUE = 64'hB105_F00D_0034_1011;
endpackage

// File: rtl/uart_id_rom.sv
// uart_id_rom: returns one byte of the fixed identification value.
// Assumes idx selects byte idx, least significant byte at idx 0.
module uart_id_rom
    import uart_regif_pkg::*;
(
    input  logic [2:0]        idx,
    output logic [BYTE_W-1:0] id_byte
);
    // Select the requested byte of the identification constant
    always_comb begin
        id_byte = ID_VALUE[idx*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// uart_irq_ctrl: raw interrupt status, mask and the delayed level output.
// Assumes set requests win over clear requests for the same bit in the same
// cycle. irq rises DELAY edges after raw&mask turns non-empty and falls in the
// same cycle the set empties, dropping any pending assertion.
module uart_irq_ctrl #(
    parameter int INT_W = 11,
    parameter int DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INT_W-1:0] set_vec,
    input  logic [INT_W-1:0] clr_vec,
    input  logic             mask_we,
    input  logic [INT_W-1:0] mask_wdata,
    output logic [INT_W-1:0] raw,
    output logic [INT_W-1:0] mask,
    output logic             irq
);
    localparam int CNT_W = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam int LOAD  = (DELAY >= 2) ? DELAY - 2 : 0;

    logic [INT_W-1:0] raw_q, mask_q;
    logic             any_now, any_prev_q, pend_q, irq_q;
    logic [CNT_W-1:0] cnt_q;

    assign any_now = |(raw_q & mask_q);

    // Raw status and mask storage; set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | set_vec;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    // Empty-to-non-empty detection and assertion delay counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_prev_q <= 1'b0;
            pend_q     <= 1'b0;
            irq_q      <= 1'b0;
            cnt_q      <= '0;
        end else begin
            any_prev_q <= any_now;
            if (!any_now) begin
                pend_q <= 1'b0;
                irq_q  <= 1'b0;
                cnt_q  <= '0;
            end else if (!any_prev_q) begin
                if (DELAY <= 1) begin
                    irq_q <= 1'b1;
                end else begin
                    pend_q <= 1'b1;
                    cnt_q  <= CNT_W'(LOAD);
                end
            end else if (pend_q) begin
                if (cnt_q == '0) begin
                    pend_q <= 1'b0;
                    irq_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign raw  = raw_q;
    assign mask = mask_q;
    assign irq  = irq_q & any_now;
endmodule

// File: rtl/uart_regif.sv
// uart_regif: memory-mapped register front end of a serial port.
// Assumes word-aligned byte addresses and at most one access per cycle.
// Read data is combinational; writes and the data-read side effect act at
// the next clock edge.
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int IRQ_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cts_in,
    input  logic              tx_empty_in,
    input  logic [INT_W-1:0]  evt_set,
    output logic              irq
);
    logic [REG_W-1:0]  store_q [N_STORE];
    logic [BYTE_W-1:0] rx_data_q, tx_byte_q, id_byte;
    logic              rx_full_q, tx_valid_q;
    logic              wr_data, rd_data, wr_mask, wr_clr, in_id;
    logic [INT_W-1:0]  set_vec, clr_vec, raw_vec, mask_vec;
    logic [REG_W-1:0]  flags;

    assign wr_data = bus_wr && (bus_addr == OFF_DATA);
    assign rd_data = bus_rd && (bus_addr == OFF_DATA);
    assign wr_mask = bus_wr && (bus_addr == OFF_MASK);
    assign wr_clr  = bus_wr && (bus_addr == OFF_CLR);
    assign in_id   = (bus_addr[ADDR_W-1:5] == OFF_ID[ADDR_W-1:5]) && (bus_addr[1:0] == 2'b00);

    // Storage-only registers, one per configured offset
    for (genvar i = 0; i < N_STORE; i++) begin : g_store
        // Hold the last value written to this offset
        always_ff @(posedge clk) begin
            if (!rst_n) store_q[i] <= '0;
            else if (bus_wr && bus_addr == STORE_OFF[i]) store_q[i] <= bus_wdata;
        end
    end

    // Transmit handoff pulse and receive holding byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_q <= 1'b0;
            tx_byte_q  <= '0;
            rx_data_q  <= '0;
            rx_full_q  <= 1'b0;
        end else begin
            tx_valid_q <= wr_data;
            if (wr_data) tx_byte_q <= bus_wdata[BYTE_W-1:0];
            if (rx_valid) begin
                rx_data_q <= rx_byte;
                rx_full_q <= 1'b1;
            end else if (rd_data) begin
                rx_full_q <= 1'b0;
            end
        end
    end

    // Raw-status set and clear requests from the bus and the byte paths
    always_comb begin
        set_vec = evt_set;
        set_vec[BIT_RX] = set_vec[BIT_RX] | rx_valid;
        set_vec[BIT_TX] = set_vec[BIT_TX] | wr_data;
        clr_vec = wr_clr ? bus_wdata[INT_W-1:0] : '0;
        clr_vec[BIT_RX] = clr_vec[BIT_RX] | rd_data;
    end

    uart_irq_ctrl #(.INT_W(INT_W), .DELAY(IRQ_DELAY)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask_we(wr_mask), .mask_wdata(bus_wdata[INT_W-1:0]),
        .raw(raw_vec), .mask(mask_vec), .irq(irq)
    );

    uart_id_rom u_id (.idx(bus_addr[4:2]), .id_byte(id_byte));

    // Flag word assembly
    always_comb begin
        flags = '0;
        flags[FLG_CTS] = cts_in;
        flags[FLG_RXE] = ~rx_full_q;
        flags[FLG_TXE] = tx_empty_in;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_DATA:  bus_rdata = {{(REG_W-BYTE_W){1'b0}}, rx_data_q};
            OFF_FLAGS: bus_rdata = flags;
            OFF_MASK:  bus_rdata = {{(REG_W-INT_W){1'b0}}, mask_vec};
            OFF_RAW:   bus_rdata = {{(REG_W-INT_W){1'b0}}, raw_vec};
            OFF_MSKD:  bus_rdata = {{(REG_W-INT_W){1'b0}}, raw_vec & mask_vec};
            default: begin
                for (int i = 0; i < N_STORE; i++)
                    if (bus_addr == STORE_OFF[i]) bus_rdata = store_q[i];
                if (in_id) bus_rdata = {{(REG_W-BYTE_W){1'b0}}, id_byte};
            end
        endcase
    end

    assign tx_valid = tx_valid_q;
    assign tx_byte  = tx_byte_q;
endmodule

// File: rtl/uart_regif_chk.sv
// uart_regif_chk: temporal checks on the register unit, bound to uart_regif.
module uart_regif_chk
    import uart_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              rx_valid,
    input logic [INT_W-1:0]  evt_set,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              irq,
    input logic [INT_W-1:0]  raw,
    input logic [INT_W-1:0]  mask
);
    p_tx_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_DATA) |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

    p_rx_sets_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> raw[BIT_RX]);

    p_clear_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CLR && evt_set == '0 && !rx_valid)
        |=> ((raw & $past(bus_wdata[INT_W-1:0])) == '0));

    p_irq_rise_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((raw & mask) != '0 && $past((raw & mask) != '0)));

    p_irq_needs_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask) != '0));
endmodule

bind uart_regif uart_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rx_valid(rx_valid), .evt_set(evt_set),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq),
    .raw(raw_vec), .mask(mask_vec)
);

// File: tb/sim_uart_regif.sv
// sim_uart_regif: scoreboard bench for uart_regif (50 MHz clock).
module sim_uart_regif;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        cts_in = 1'b0, tx_empty_in = 1'b1;
    logic [10:0] evt_set = '0;
    logic        irq;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] txq [$];

    always #10 clk = ~clk;

    uart_regif #(.IRQ_DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .cts_in(cts_in), .tx_empty_in(tx_empty_in),
        .evt_set(evt_set), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == 12'h000) txq.push_back(d[7:0]);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse_evt(input logic [10:0] e);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    // irq must stay low for D-1 more edges and be high after edge D
    task automatic irq_timing(input string req);
        for (int k = 0; k < D; k++) begin
            check(req, {15'b0, irq}, 16'h0);
            @(negedge clk);
        end
        check(req, {15'b0, irq}, 16'h1);
    endtask

    // Monitor: pop expected transmit bytes as the design hands them out
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (txq.size() == 0) check("R3 unexpected tx", {8'b0, tx_byte}, 16'hFFFF);
            else check("R3 tx byte", {8'b0, tx_byte}, {8'b0, txq.pop_front()});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        bit stayed_low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 flags
        check("R1 irq", {15'b0, irq}, 16'h0);
        rd_chk("R1 mask", 12'h038, 16'h0);
        rd_chk("R1 raw", 12'h03C, 16'h0);
        rd_chk("R1 control", 12'h030, 16'h0);
        rd_chk("R11 flags idle", 12'h018, 16'h0090);

        // R2 storage readback
        wr(12'h024, 16'hBEEF); wr(12'h028, 16'h0015); wr(12'h02C, 16'h7060);
        wr(12'h030, 16'h8301); wr(12'h034, 16'hFFFF);
        rd_chk("R2 int div", 12'h024, 16'hBEEF);
        rd_chk("R2 frac div", 12'h028, 16'h0015);
        rd_chk("R2 line", 12'h02C, 16'h7060);
        rd_chk("R2 control", 12'h030, 16'h8301);
        rd_chk("R2 level", 12'h034, 16'hFFFF);

        // R13 read-only writes ignored, unmapped reads zero
        wr(12'h03C, 16'h07FF); wr(12'h018, 16'hFFFF); wr(12'hFE0, 16'h00AA);
        rd_chk("R13 raw unchanged", 12'h03C, 16'h0);
        rd_chk("R13 id unchanged", 12'hFE0, 16'h0011);
        rd_chk("R13 unmapped", 12'h100, 16'h0);

        // R12 identification bytes
        for (int i = 0; i < 8; i++)
            rd_chk("R12 id", 12'hFE0 + 12'(4 * i), {8'b0, 8'(64'hB105F00D00341011 >> (8 * i))});

        // R11 flag inputs
        cts_in = 1'b1; tx_empty_in = 1'b0;
        rd_chk("R11 flags cts", 12'h018, 16'h0011);
        cts_in = 1'b0; tx_empty_in = 1'b1;

        // R3 transmit handoff and raw bit 5
        wr(12'h000, 16'h01A5);
        wr(12'h000, 16'h003C);
        rd_chk("R3 raw tx", 12'h03C, 16'h0020);
        rd_chk("R5 masked none", 12'h040, 16'h0);
        check("R3 no irq unmasked", {15'b0, irq}, 16'h0);

        // R10 mask write schedules, R8 exact delay
        wr(12'h038, 16'hFFFF);
        irq_timing("R10 mask write delay");
        rd_chk("R5 mask readback", 12'h038, 16'h07FF);
        rd_chk("R5 masked", 12'h040, 16'h0020);

        // R9 fall same cycle as clear, R6 clear
        wr(12'h044, 16'h0020);
        check("R9 immediate fall", {15'b0, irq}, 16'h0);
        rd_chk("R6 raw cleared", 12'h03C, 16'h0);

        // R9 cancel a pending assertion
        wr(12'h038, 16'h0080);
        pulse_evt(11'h080);
        @(negedge clk);
        wr(12'h044, 16'h0080);
        stayed_low = 1;
        for (int k = 0; k < D + 3; k++) begin
            if (irq) stayed_low = 0;
            @(negedge clk);
        end
        check("R9 cancelled", {15'b0, stayed_low}, 16'h1);

        // R8 fresh full delay after cancel, via event input
        pulse_evt(11'h080);
        irq_timing("R8 event delay");
        wr(12'h044, 16'h07FF);
        check("R9 low after clear", {15'b0, irq}, 16'h0);

        // R4 receive path
        rx_byte = 8'h5C; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rd_chk("R4 raw rx", 12'h03C, 16'h0010);
        rd_chk("R4 flags not empty", 12'h018, 16'h0080);
        rd_chk("R4 data", 12'h000, 16'h005C);
        rd_chk("R4 raw rx cleared", 12'h03C, 16'h0);
        rd_chk("R4 flags empty", 12'h018, 16'h0090);

        // R6 set wins over clear in the same cycle
        evt_set = 11'h400;
        wr(12'h044, 16'h0400);
        evt_set = '0;
        rd_chk("R6 set wins", 12'h03C, 16'h0400);
        wr(12'h044, 16'h0400);

        // R7 event bit positions
        wr(12'h038, 16'h0000);
        pulse_evt(11'h341);
        rd_chk("R7 raw events", 12'h03C, 16'h0341);
        wr(12'h044, 16'h07FF);
        rd_chk("R7 raw cleared", 12'h03C, 16'h0);

        repeat (2) @(negedge clk);
        check("R3 tx queue drained", 16'(txq.size()), 16'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule